// File: doc/BRIEF.md
# Byte-wide floating-point multiplier

This block multiplies two numbers held in a one-byte floating-point format. Each byte carries a sign in bit 7, a 4-bit exponent with bias 7 in bits 6:3 and a 3-bit fraction in bits 2:0. The fraction sits behind an implied leading one, so a nonzero operand has the value (1 + f/8) * 2^(e-7). Only normalized values and zero are represented. An exponent field of zero means zero. Subnormals, infinities and NaN have no encoding.

The multiplier makes each operand's hidden one explicit and forms the 8-bit product of the two 4-bit significands. If that product is 2 or more, it moves the product one place right and raises the exponent by one. It then keeps only the top three fraction bits, with no rounding. The result exponent is the sum of the operand exponents minus the bias, plus the normalization step. Results that fall outside the format are saturated or flushed.

Operands are taken on a cycle with `in_valid` high. The product appears in a register one clock later, flagged by `out_valid`.

Top module: `fp8_mul`

## Requirements
- R1: The significand product is (8+fa)*(8+fb), where fa and fb are the 3-bit fraction fields (bits 2:0) and the hidden one is restored as weight 8.
- R2: The result sign (bit 7) is the XOR of the two operand sign bits, in every case including zero, saturated and flushed results.
- R3: When the significand product is 128 or more (a value of 2.0 or above), it is shifted right by one place and the exponent is raised by one.
- R4: The result fraction is the three bits just below the leading one of the normalized product. Lower bits are discarded without rounding; for example 0x3E times 0x4A gives 0x50.
- R5: For nonzero operands, the result exponent field (bits 6:3) equals ea + eb - 7 + n, where n is 1 if normalization shifted and 0 otherwise.
- R6: If either operand has exponent field 0, the result is a signed zero: sign per R2, and bits 6:0 are zero.
- R7: If the final exponent of R5 exceeds 15, the result is the largest finite magnitude, with exponent field 15 and fraction 7, and the sign per R2.
- R8: If the final exponent of R5 is below 1, the result is a signed zero.
- R9: A cycle with `in_valid` high produces `out_valid` high, with the matching `result`, exactly one clock later. A cycle with `in_valid` low produces `out_valid` low one clock later.
- R10: After a synchronous active-high reset, `out_valid` is 0 and `result` is 0x00.
- R11: While `in_valid` is low, `result` holds its previous value whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on `a_in`/`b_in` are valid this cycle |
| a_in | input | 8 | First operand, byte float |
| b_in | input | 8 | Second operand, byte float |
| out_valid | output | 1 | `result` holds a fresh product |
| result | output | 8 | Registered product, byte float |

## Verification
Normalization and the range checks can act in the same cycle, because the one-place shift moves the exponent across a limit. An exponent sum of 22 overflows only when the product is 2 or more. An exponent sum of 7 is rescued from flushing by the same shift. The zero rule can also meet either range case. The bench sweeps all 65536 operand pairs back to back, so every such combination occurs. It then adds random pairs with idle gaps and directed boundary pairs. Each output is judged against a reference function that applies the rules in order: zero, then normalize, then saturate or flush.

// File: rtl/fp8_mul_pkg.sv
package fp8_mul_pkg;

    localparam int EXP_W   = 4;
    localparam int FRAC_W  = 3;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int ESUM_W  = EXP_W + 2;

    typedef struct packed {
        logic              sgn;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp8_t;

    typedef struct packed {
        logic              sgn;
        logic              zero;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
    } operand_t;

    function automatic fp8_t signed_zero(input logic s);
        fp8_t r;
        r.sgn  = s;
        r.exp  = '0;
        r.frac = '0;
        return r;
    endfunction

    function automatic fp8_t largest_finite(input logic s);
        fp8_t r;
        r.sgn  = s;
        r.exp  = '1;
        r.frac = '1;
        return r;
    endfunction

endpackage

// File: rtl/fp8_unpack.sv
module fp8_unpack
    import fp8_mul_pkg::*;
(
    input  fp8_t     word,
    output operand_t op
);
    always_comb begin
        op.sgn  = word.sgn;
        op.exp  = word.exp;
        op.zero = (word.exp == '0);
        op.sig  = {1'b1, word.frac};
    end
endmodule

// File: rtl/fp8_sig_mul.sv
module fp8_sig_mul
    import fp8_mul_pkg::*;
(
    input  logic [SIG_W-1:0]  sig_a,
    input  logic [SIG_W-1:0]  sig_b,
    output logic              norm_shift,
    output logic [FRAC_W-1:0] frac
);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] aligned;

    always_comb begin
        prod       = PROD_W'(sig_a) * PROD_W'(sig_b);
        norm_shift = prod[PROD_W-1];
        aligned    = norm_shift ? (prod >> 1) : prod;
        frac       = FRAC_W'(aligned >> (PROD_W - 2 - FRAC_W));
    end
endmodule

// File: rtl/fp8_exp_pack.sv
module fp8_exp_pack
    import fp8_mul_pkg::*;
(
    input  operand_t          op_a,
    input  operand_t          op_b,
    input  logic              norm_shift,
    input  logic [FRAC_W-1:0] frac,
    output fp8_t              packed_res
);
    localparam logic [ESUM_W-1:0] OVF_LIMIT = ESUM_W'(EXP_MAX + BIAS);
    localparam logic [ESUM_W-1:0] UNF_LIMIT = ESUM_W'(1 + BIAS);

    logic              sgn;
    logic [ESUM_W-1:0] esum;

    always_comb begin
        sgn  = op_a.sgn ^ op_b.sgn;
        esum = ESUM_W'(op_a.exp) + ESUM_W'(op_b.exp) + ESUM_W'(norm_shift);
        if (op_a.zero || op_b.zero) begin
            packed_res = signed_zero(sgn);
        end else if (esum > OVF_LIMIT) begin
            packed_res = largest_finite(sgn);
        end else if (esum < UNF_LIMIT) begin
            packed_res = signed_zero(sgn);
        end else begin
            packed_res.sgn  = sgn;
            packed_res.exp  = EXP_W'(esum - ESUM_W'(BIAS));
            packed_res.frac = frac;
        end
    end
endmodule

// File: rtl/fp8_mul.sv
module fp8_mul
    import fp8_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    fp8_t              word_a, word_b, next_res;
    operand_t          op_a, op_b;
    logic              norm_shift;
    logic [FRAC_W-1:0] frac;

    assign word_a = a_in;
    assign word_b = b_in;

    fp8_unpack u_unpack_a (.word(word_a), .op(op_a));
    fp8_unpack u_unpack_b (.word(word_b), .op(op_b));

    fp8_sig_mul u_sig_mul (
        .sig_a      (op_a.sig),
        .sig_b      (op_b.sig),
        .norm_shift (norm_shift),
        .frac       (frac)
    );

    fp8_exp_pack u_exp_pack (
        .op_a       (op_a),
        .op_b       (op_b),
        .norm_shift (norm_shift),
        .frac       (frac),
        .packed_res (next_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_res;
            end
        end
    end
endmodule

// File: rtl/fp8_mul_chk.sv
module fp8_mul_chk
    import fp8_mul_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] a_in,
    input logic [WORD_W-1:0] b_in,
    input logic              out_valid,
    input logic [WORD_W-1:0] result
);
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r11_hold_result: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    a_r2_sign_xor: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> result[WORD_W-1] == $past(a_in[WORD_W-1] ^ b_in[WORD_W-1]));

    a_r6_zero_operand: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (a_in[WORD_W-2:FRAC_W] == '0 || b_in[WORD_W-2:FRAC_W] == '0))
        |=> result[WORD_W-2:0] == '0);

    a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
        (in_valid && a_in[WORD_W-2:FRAC_W] != '0 && b_in[WORD_W-2:FRAC_W] != '0 &&
         (int'(a_in[WORD_W-2:FRAC_W]) + int'(b_in[WORD_W-2:FRAC_W]) > EXP_MAX + BIAS))
        |=> result[WORD_W-2:0] == '1);
endmodule

bind fp8_mul fp8_mul_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a_in      (a_in),
    .b_in      (b_in),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/fp8_mul_test.sv
`timescale 1ns/1ps
module fp8_mul_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;
    logic       out_valid;
    logic [7:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] last_res = 8'h00;
    int seed_dummy;

    always #2 clk = ~clk;

    fp8_mul uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        int s, ea, eb, p, e;
        s  = a[7] ^ b[7];
        ea = int'(a[6:3]);
        eb = int'(b[6:3]);
        if (ea == 0 || eb == 0) return {s[0], 7'd0};
        p = (8 + int'(a[2:0])) * (8 + int'(b[2:0]));
        e = ea + eb - 7;
        if (p >= 128) begin
            p = p / 2;
            e = e + 1;
        end
        if (e > 15) return {s[0], 7'h7F};
        if (e < 1)  return {s[0], 7'd0};
        return {s[0], 4'(e), 3'((p / 8) % 8)};
    endfunction

    function automatic string req_tag(input logic [7:0] a, input logic [7:0] b);
        int ea, eb, e;
        ea = int'(a[6:3]);
        eb = int'(b[6:3]);
        if (ea == 0 || eb == 0) return "R6";
        e = ea + eb - 7 + (((8 + int'(a[2:0])) * (8 + int'(b[2:0])) >= 128) ? 1 : 0);
        if (e > 15) return "R7";
        if (e < 1)  return "R8";
        if ((8 + int'(a[2:0])) * (8 + int'(b[2:0])) >= 128) return "R3";
        return "R5";
    endfunction

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL %s: actual valid/result=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // one operation: drive at negedge, sample 1 ns after the capturing edge
    task automatic do_op(input logic v, input logic [7:0] a, input logic [7:0] b, input string tag);
        logic [7:0] exp_r;
        @(negedge clk);
        in_valid = v;
        a_in = a;
        b_in = b;
        exp_r = v ? ref_mul(a, b) : last_res;
        @(posedge clk);
        #1;
        check(v ? tag : "R11", {out_valid, result}, {v, exp_r});
        last_res = exp_r;
    endtask

    initial begin
        #(4 * 190000);
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        seed_dummy = int'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R10", {out_valid, result}, 9'h000);
        @(negedge clk);
        rst = 1'b0;

        // R4 worked example: 1.110*2^0 times 1.010*2^2 -> 1.000*2^3
        do_op(1'b1, 8'h3E, 8'h4A, "R4");
        check("R4", {1'b1, result}, 9'h150);
        // R1: 1.111 * 1.111 = 225/64, normalizes, fraction 110
        do_op(1'b1, 8'h3F, 8'h3F, "R1");
        // R2: negative times positive
        do_op(1'b1, 8'hBF, 8'h38, "R2");
        // R3 with R7 at boundary: 11+11 no shift stays 15, with shift saturates
        do_op(1'b1, 8'h58, 8'h58, "R5");
        do_op(1'b1, 8'h5F, 8'h5F, "R7");
        // R8 boundary: exponent sum 7 rescued by shift, not rescued without
        do_op(1'b1, 8'h0F, 8'h37, "R3");
        do_op(1'b1, 8'h08, 8'h30, "R8");
        // R6 zero with sign
        do_op(1'b1, 8'h80, 8'h7F, "R6");
        // R11 idle with changing inputs
        do_op(1'b0, 8'h55, 8'h66, "R11");
        do_op(1'b0, 8'hFF, 8'h11, "R11");
        // R9 exhaustive back-to-back sweep
        for (int i = 0; i < 65536; i++) begin
            do_op(1'b1, 8'(i >> 8), 8'(i), req_tag(8'(i >> 8), 8'(i)));
        end
        // random pairs with idle gaps
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] ra, rb;
            ra = 8'($urandom);
            rb = 8'($urandom);
            do_op(($urandom % 4) != 0, ra, rb, req_tag(ra, rb));
        end
        // R10 reset in mid-stream
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R10", {out_valid, result}, 9'h000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule